// File: doc/BRIEF.md
# Write-Instruction Clock-Count Guard

This block sits beside the serial command decoder of a three-wire serial memory. It counts the rising serial-clock edges seen inside one chip-select session, from the clock that carries the start bit up to the moment chip select drops. When the session carried a programming command, the block compares that count with the exact length the command needs. It then either permits the write sequencer to program the array or cancels the command.

The check exists because of noise. A noise pulse or a clock counted twice can shift a harmless pattern into a destructive one. One example is a write-disable pattern that turns into an erase of address 0 after a single spurious edge. Any count that differs from the required length, longer or shorter, cancels the command.

The clock input is a synchronised one-cycle strobe per serial-clock rising edge, and the start input marks the strobe that carries the start bit. The decoded instruction class must be valid in the cycle in which chip select is first seen low.

Top module: `wcg_guard`

## Requirements
- R1: Class codes on `cls_i` are: 0 none, 1 read, 2 write-enable, 3 write-disable, 4 word write, 5 word erase, 6 chip write, 7 chip erase. Classes 4 and 6 yield a `permit_o` pulse when exactly 3 + ADDR_W + DATA_W edges were counted (27 with the defaults).
- R2: Classes 5 and 7 yield a `permit_o` pulse when exactly 3 + ADDR_W edges were counted (11 with the defaults).
- R3: For a guarded class (4 to 7), a count above the required length yields a `cancel_o` pulse and no `permit_o`. This includes a write-disable pattern that noise turned into an erase with one extra edge.
- R4: For a guarded class, a non-zero count below the required length yields `cancel_o` and no `permit_o`.
- R5: Edges that arrive before the start-bit edge are not counted.
- R6: The count saturates, so a burst long enough to wrap a plain counter back onto the required length still cancels.
- R7: Classes 0 to 3 never produce `permit_o` or `cancel_o`.
- R8: A verdict appears in the cycle after the first cycle in which `cs_i` is sampled low, lasts exactly one cycle, and `permit_o` and `cancel_o` are never high together.
- R9: While `cs_i` is low, edges are ignored and no verdict is issued. This includes an edge that coincides with the falling of `cs_i`. A session with no start bit issues no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Synchronised chip select, high = session active |
| sk_rise_i | input | 1 | One-cycle strobe per serial-clock rising edge |
| start_i | input | 1 | Marks the strobe that carries the start bit |
| cls_i | input | 3 | Decoded instruction class |
| permit_o | output | 1 | One-cycle pulse: programming may proceed |
| cancel_o | output | 1 | One-cycle pulse: guarded command vetoed |

## Verification
The verdict is registered on the cycle in which `cs_i` is first sampled low, so it is due exactly one clock after that sample and must be gone one clock later. The bench drives every input on falling clock edges. It reads the verdict at the falling edge that follows the first low chip-select sample, and reads it again one falling edge later to confirm the pulse has ended. Before chip select is dropped, it also samples the outputs to confirm that nothing was issued early.

// File: rtl/guard_pkg.sv
package guard_pkg;

  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_READ  = 3'd1,
    CLS_WEN   = 3'd2,
    CLS_WDIS  = 3'd3,
    CLS_WORD  = 3'd4,
    CLS_ERASE = 3'd5,
    CLS_WALL  = 3'd6,
    CLS_EALL  = 3'd7
  } cls_e;

  function automatic logic cls_guarded(input cls_e c);
    return (c == CLS_WORD) || (c == CLS_ERASE) || (c == CLS_WALL) || (c == CLS_EALL);
  endfunction

  function automatic logic cls_has_data(input cls_e c);
    return (c == CLS_WORD) || (c == CLS_WALL);
  endfunction

endpackage

// File: rtl/guard_edge_cnt.sv
module guard_edge_cnt #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             sk_rise_i,
  input  logic             start_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             armed_o
);

  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!cs_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (sk_rise_i) begin
      if (!armed_q) begin
        // dummy edges before the start bit leave the counter idle
        if (start_i) begin
          cnt_q   <= CNT_W'(1);
          armed_q <= 1'b1;
        end
      end else if (cnt_q != CntMax) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign armed_o = armed_q;

endmodule

// File: rtl/guard_req_len.sv
module guard_req_len
  import guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 6
) (
  input  cls_e             cls_i,
  output logic [CNT_W-1:0] req_o,
  output logic             guarded_o
);

  localparam int unsigned LenShort = 3 + ADDR_W;
  localparam int unsigned LenLong  = LenShort + DATA_W;

  always_comb begin
    guarded_o = cls_guarded(cls_i);
    if (cls_has_data(cls_i)) req_o = CNT_W'(LenLong);
    else                     req_o = CNT_W'(LenShort);
  end

endmodule

// File: rtl/guard_verdict.sv
module guard_verdict #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             armed_i,
  input  logic             guarded_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] req_i,
  output logic             permit_o,
  output logic             cancel_o
);

  logic cs_q;
  logic cs_fall;
  logic judge;
  logic match;

  assign cs_fall = cs_q & ~cs_i;
  assign judge   = cs_fall & armed_i & guarded_i;
  assign match   = (cnt_i == req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q     <= 1'b0;
      permit_o <= 1'b0;
      cancel_o <= 1'b0;
    end else begin
      cs_q     <= cs_i;
      permit_o <= judge & match;
      cancel_o <= judge & ~match;
    end
  end

endmodule

// File: rtl/wcg_guard.sv
module wcg_guard
  import guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       sk_rise_i,
  input  logic       start_i,
  input  logic [2:0] cls_i,
  output logic       permit_o,
  output logic       cancel_o
);

  localparam int unsigned LenLong = 3 + ADDR_W + DATA_W;
  // one spare bit so saturation sits well above any valid length
  localparam int unsigned CNT_W   = $clog2(LenLong + 1) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] req;
  logic             armed;
  logic             guarded;

  guard_edge_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_i     (cs_i),
    .sk_rise_i(sk_rise_i),
    .start_i  (start_i),
    .cnt_o    (cnt),
    .armed_o  (armed)
  );

  guard_req_len #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_len (
    .cls_i    (cls_e'(cls_i)),
    .req_o    (req),
    .guarded_o(guarded)
  );

  guard_verdict #(.CNT_W(CNT_W)) u_vrd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_i     (cs_i),
    .armed_i  (armed),
    .guarded_i(guarded),
    .cnt_i    (cnt),
    .req_i    (req),
    .permit_o (permit_o),
    .cancel_o (cancel_o)
  );

endmodule

// File: rtl/guard_chk.sv
module guard_chk #(
  parameter int unsigned CNT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_i,
  input logic [2:0]       cls_i,
  input logic             permit_o,
  input logic             cancel_o,
  input logic [CNT_W-1:0] cnt_i
);

  localparam logic [CNT_W-1:0] CntMax = '1;

  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(permit_o && cancel_o));

  p_permit_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    permit_o |=> !permit_o);

  p_cancel_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |=> !cancel_o);

  p_after_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (permit_o || cancel_o) |-> (!$past(cs_i) && $past(cs_i, 2)));

  p_guarded_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (permit_o || cancel_o) |-> $past(cls_i[2]));

  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_i && !$past(cs_i)) |=> !(permit_o || cancel_o));

  p_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && cnt_i == CntMax) |=> (cnt_i == CntMax));

endmodule

bind wcg_guard guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_i    (cs_i),
  .cls_i   (cls_i),
  .permit_o(permit_o),
  .cancel_o(cancel_o),
  .cnt_i   (cnt)
);

// File: tb/wcg_guard_bench.sv
module wcg_guard_bench;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int SHORT  = 3 + ADDR_W;
  localparam int LONG   = SHORT + DATA_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_i = 1'b0;
  logic sk_rise_i = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] cls_i = 3'd0;
  logic permit_o, cancel_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  wcg_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wcg_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .sk_rise_i(sk_rise_i),
    .start_i(start_i), .cls_i(cls_i), .permit_o(permit_o), .cancel_o(cancel_o)
  );

  always #4 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired act=%0d exp<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // verdict code: 0 none, 1 permit, 2 cancel, 3 both
  task automatic session(input int dummies, input int n, input int cls, input bit edge_at_fall,
                         output int early, output int v, output int after);
    @(negedge clk_i);
    cs_i = 1'b1;
    cls_i = 3'(cls);
    @(negedge clk_i);
    for (int i = 0; i < dummies; i++) begin
      sk_rise_i = 1'b1; start_i = 1'b0;
      @(negedge clk_i); sk_rise_i = 1'b0;
      @(negedge clk_i);
    end
    for (int i = 0; i < n; i++) begin
      sk_rise_i = 1'b1; start_i = (i == 0);
      @(negedge clk_i); sk_rise_i = 1'b0; start_i = 1'b0;
      @(negedge clk_i);
    end
    early = {30'd0, cancel_o, permit_o};
    cs_i = 1'b0;
    sk_rise_i = edge_at_fall;
    @(negedge clk_i);
    sk_rise_i = 1'b0;
    v = {30'd0, cancel_o, permit_o};
    @(negedge clk_i);
    after = {30'd0, cancel_o, permit_o};
    @(negedge clk_i);
  endtask

  function automatic int expect_v(input int n, input int cls);
    int req;
    if (cls < 4 || n == 0) return 0;
    req = (cls == 4 || cls == 6) ? LONG : SHORT;
    return (n == req) ? 1 : 2;
  endfunction

  function automatic string tag_for(input int n, input int cls);
    int req;
    if (cls < 4) return "R7";
    if (n == 0) return "R9";
    req = (cls == 4 || cls == 6) ? LONG : SHORT;
    if (n == req) return (req == LONG) ? "R1" : "R2";
    return (n > req) ? "R3" : "R4";
  endfunction

  initial begin
    int e, v, a;
    repeat (3) @(negedge clk_i);
    check({cancel_o, permit_o} == 2'b00, "R8 reset outputs", {cancel_o, permit_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // sweep every class against every count up to past the long length
    for (int cls = 0; cls < 8; cls++) begin
      for (int n = 0; n <= LONG + 4; n++) begin
        session(0, n, cls, 1'b0, e, v, a);
        check(v == expect_v(n, cls), tag_for(n, cls), v, expect_v(n, cls));
        check(e == 0, "R8 no early verdict", e, 0);
        check(a == 0, "R8 one-cycle pulse", a, 0);
      end
    end

    // R3: write-disable plus one noise edge decoded as erase at address 0
    session(0, SHORT + 1, 5, 1'b0, e, v, a);
    check(v == 2, "R3 noise-shifted erase", v, 2);

    // R5: dummy edges do not count
    session(5, SHORT, 5, 1'b0, e, v, a);
    check(v == 1, "R5 dummies then exact erase", v, 1);
    session(3, SHORT - 3, 7, 1'b0, e, v, a);
    check(v == 2, "R5 dummies not added", v, 2);
    session(7, LONG, 6, 1'b0, e, v, a);
    check(v == 1, "R5 dummies then exact chip write", v, 1);

    // R6: bursts that would wrap a plain counter onto the valid length
    session(0, SHORT + 64, 5, 1'b0, e, v, a);
    check(v == 2, "R6 erase wrap burst", v, 2);
    session(0, LONG + 64, 4, 1'b0, e, v, a);
    check(v == 2, "R6 write wrap burst", v, 2);
    session(0, SHORT + 128, 7, 1'b0, e, v, a);
    check(v == 2, "R6 chip erase double wrap", v, 2);

    // R9: edge coinciding with chip-select fall is ignored
    session(0, LONG, 4, 1'b1, e, v, a);
    check(v == 1, "R9 edge at fall ignored (exact)", v, 1);
    session(0, SHORT - 1, 5, 1'b1, e, v, a);
    check(v == 2, "R9 edge at fall not counted", v, 2);

    // R9: edges while chip select low do nothing
    @(negedge clk_i);
    cls_i = 3'd5;
    for (int i = 0; i < SHORT; i++) begin
      sk_rise_i = 1'b1; start_i = (i == 0);
      @(negedge clk_i); sk_rise_i = 1'b0; start_i = 1'b0;
      check({cancel_o, permit_o} == 2'b00, "R9 cs low idle", {cancel_o, permit_o}, 0);
      @(negedge clk_i);
    end
    check({cancel_o, permit_o} == 2'b00, "R9 cs low end", {cancel_o, permit_o}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule